// File: doc/BRIEF.md
# Bidirectional Handshaked Parallel Port

This block is one 8-bit parallel port that moves bytes in both directions over a single shared set of external data lines. Each direction has its own handshake. For incoming data, the peer drives the lines and pulses an active-low strobe, and the port keeps the byte in an input latch until the host reads it. For outgoing data, the host writes a byte into an output latch. The port then drives the lines with that byte only while the peer holds its active-low acknowledge low. At all other times the lines float.

Two flags describe the buffers: an active-high input-full flag and an active-low output-full flag. Both are visible to the host and to the peer. One interrupt request covers both directions, and two host-controlled enable bits gate it. The strobe and acknowledge inputs are asynchronous. Each passes through a flop synchronizer, and the port acts on the falling edge it detects after that synchronizer.

Top module: `bidir_port`

## Requirements
- R1: After reset, `in_full` is 0, `out_full_n` is 1 (output buffer empty), and `irq` is 0 while both enables are 0.
- R2: A falling edge on `stb_n` copies the `pad` value into the input latch. `in_full` rises on the third rising clock edge after `stb_n` goes low (two synchronizer stages plus the flag register), and not before.
- R3: The input latch holds its byte on `host_rdata` until the next strobe. A host read (`host_rd`=1 for one cycle) clears `in_full` at the next clock edge.
- R4: A host write (`host_wr`=1) loads `host_wdata` into the output latch and drives `out_full_n` to 0 at the next clock edge.
- R5: A falling edge on `ack_n` returns `out_full_n` to 1 on the third rising clock edge after `ack_n` goes low.
- R6: The port drives `pad` with the output latch only while the synchronized `ack_n` is low. At all other times `pad` is high-impedance, so the peer's byte can be captured without contention.
- R7: `irq` = (`in_full` AND `ie_in`) OR (`out_full_n` AND `ie_out`). A cleared enable masks its condition.
- R8: When a detected strobe edge and a host read meet in the same cycle, the set wins and `in_full` stays 1 with the new byte. When a detected acknowledge edge and a host write meet in the same cycle, the write wins and `out_full_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the output latch |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read of the input latch; clears `in_full` |
| host_rdata | output | 8 | Contents of the input latch |
| ie_in | input | 1 | Interrupt enable for the input-full condition |
| ie_out | input | 1 | Interrupt enable for the output-empty condition |
| pad | inout | 8 | Shared tri-state external data lines |
| stb_n | input | 1 | Active-low strobe from the peer (asynchronous) |
| ack_n | input | 1 | Active-low acknowledge from the peer (asynchronous) |
| in_full | output | 1 | Input latch holds an unread byte |
| out_full_n | output | 1 | Low while the output latch holds a byte the peer has not taken |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong synchronizer depth or a missing edge register shows up as `in_full` or `out_full_n` changing one cycle early or late relative to the strobe or acknowledge. The bench samples the cycle just before the expected change and the cycle just after it, so either error is caught. A capture at the wrong moment, or a latch that is not held, shows up as a wrong byte on `host_rdata` when the scoreboard pops the next read. Wrong collision priority appears one cycle after the collision as a cleared flag. A broken drive enable appears as a wrong byte on `pad` within three cycles of `ack_n` falling, or as a corrupted peer byte read back through the input path.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned BDP_DW = 8;

  // falling edge seen between a registered copy and the current level
  function automatic logic fell(input logic prev, input logic now);
    return prev & ~now;
  endfunction

  // combined interrupt request
  function automatic logic irq_of(input logic full_in, input logic en_in,
                                  input logic empty_out, input logic en_out);
    return (full_in & en_in) | (empty_out & en_out);
  endfunction
endpackage

// File: rtl/bdp_sync.sv
module bdp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff[0] <= 1'b1;
          else        ff[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff[i] <= 1'b1;
          else        ff[i] <= ff[i-1];
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/bdp_in_path.sv
module bdp_in_path
  import bdp_pkg::*;
#(
  parameter int unsigned DW = BDP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_lvl,
  input  logic [DW-1:0] pad_in,
  input  logic          rd,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          stb_fall
);
  logic stb_prev;

  assign stb_fall = fell(stb_prev, stb_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b1;
      data_o   <= '0;
      full_o   <= 1'b0;
    end else begin
      stb_prev <= stb_lvl;
      if (stb_fall) begin
        data_o <= pad_in;
        full_o <= 1'b1;
      end else if (rd) begin
        full_o <= 1'b0;
      end
    end
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> (full_o && data_o == $past(pad_in)));
  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !stb_fall) |=> !full_o);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> $stable(data_o));
endmodule

// File: rtl/bdp_out_path.sv
module bdp_out_path
  import bdp_pkg::*;
#(
  parameter int unsigned DW = BDP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_lvl,
  output logic [DW-1:0] data_o,
  output logic          full_n_o,
  output logic          drive_o
);
  logic ack_prev;
  logic ack_fall;

  assign ack_fall = fell(ack_prev, ack_lvl);
  assign drive_o  = ~ack_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev <= 1'b1;
      data_o   <= '0;
      full_n_o <= 1'b1;
    end else begin
      ack_prev <= ack_lvl;
      if (wr) begin
        data_o   <= wdata;
        full_n_o <= 1'b0;
      end else if (ack_fall) begin
        full_n_o <= 1'b1;
      end
    end
  end

  // R4
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!full_n_o && data_o == $past(wdata)));
  // R5
  ack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !wr) |=> full_n_o);
  // R6
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |-> drive_o);
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bdp_pkg::*;
#(
  parameter int unsigned DW          = BDP_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          ie_in,
  input  logic          ie_out,
  inout  wire  [DW-1:0] pad,
  input  logic          stb_n,
  input  logic          ack_n,
  output logic          in_full,
  output logic          out_full_n,
  output logic          irq
);
  logic          stb_lvl, ack_lvl, drive_en, stb_fall;
  logic [DW-1:0] out_data;

  bdp_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d(stb_n), .q(stb_lvl));
  bdp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_lvl));

  bdp_in_path #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .stb_lvl(stb_lvl), .pad_in(pad), .rd(host_rd),
    .data_o(host_rdata), .full_o(in_full), .stb_fall(stb_fall));

  bdp_out_path #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .ack_lvl(ack_lvl), .data_o(out_data), .full_n_o(out_full_n),
    .drive_o(drive_en));

  assign pad = drive_en ? out_data : {DW{1'bz}};
  assign irq = irq_of(in_full, ie_in, out_full_n, ie_out);

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_in && !ie_out) |-> !irq);
  // R8
  rd_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && host_rd) |=> in_full);
  // R6
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_lvl |-> !drive_en);
endmodule

// File: tb/sim_bidir_port.sv
`timescale 1ns/1ps
module sim_bidir_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, ie_in = 1'b0, ie_out = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic       in_full, out_full_n, irq;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_val = '0;
  wire  [7:0] pad;
  int         errors = 0, checks = 0;
  logic [7:0] in_q[$];
  logic [7:0] out_q[$];
  bit         done = 1'b0;

  assign pad = tb_drv ? tb_val : 8'bzzzzzzzz;
  always #4 clk = ~clk;

  bidir_port u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .ie_in(ie_in), .ie_out(ie_out),
    .pad(pad), .stb_n(stb_n), .ack_n(ack_n), .in_full(in_full),
    .out_full_n(out_full_n), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: each host read pops the expected byte
  always @(negedge clk) begin
    #2;
    if (host_rd) begin
      if (in_q.size() == 0) check("R3 unexpected read", 8'h00, 8'hff);
      else check("R3 read data", host_rdata, in_q.pop_front());
    end
  end

  task automatic host_read();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_wdata = v; out_q.push_back(v);
    @(negedge clk); host_wr = 1'b0;
  endtask

  // peer sends a byte; checks R2 latency
  task automatic peer_send(input logic [7:0] v);
    @(negedge clk); tb_drv = 1'b1; tb_val = v; stb_n = 1'b0; in_q.push_back(v);
    repeat (2) @(posedge clk);
    @(negedge clk); check("R2 flag not early", {7'd0, in_full}, 8'd0);
    @(negedge clk); check("R2 flag set", {7'd0, in_full}, 8'd1);
    stb_n = 1'b1;
    repeat (3) @(negedge clk);
    tb_drv = 1'b0;
  endtask

  // peer takes the pending byte; checks R5 and R6
  task automatic peer_take();
    @(negedge clk); ack_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); check("R5 empty not early", {7'd0, out_full_n}, 8'd0);
    check("R6 pad driven", pad, out_q[0]);
    @(negedge clk); check("R5 empty set", {7'd0, out_full_n}, 8'd1);
    check("R6 pad held", pad, out_q.pop_front());
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_full", {7'd0, in_full}, 8'd0);
    check("R1 out_full_n", {7'd0, out_full_n}, 8'd1);
    check("R1 irq", {7'd0, irq}, 8'd0);

    // R2 R3 basic inbound, several patterns; pad floats so the peer drives cleanly (R6)
    peer_send(8'hA5); host_read();
    @(negedge clk); check("R3 flag cleared", {7'd0, in_full}, 8'd0);
    peer_send(8'h3C); host_read();
    peer_send(8'hFF); host_read();
    peer_send(8'h00); host_read();

    // R4 R5 R6 outbound
    host_write(8'h5A);
    check("R4 full after write", {7'd0, out_full_n}, 8'd0);
    peer_take();
    host_write(8'hC3); peer_take();

    // R7 irq
    ie_in = 1'b1;
    peer_send(8'h81);
    check("R7 irq input", {7'd0, irq}, 8'd1);
    host_read();
    @(negedge clk); check("R7 irq input clear", {7'd0, irq}, 8'd0);
    ie_in = 1'b0; ie_out = 1'b1;
    @(negedge clk); check("R7 irq output empty", {7'd0, irq}, 8'd1);
    host_write(8'h11);
    check("R7 irq output full", {7'd0, irq}, 8'd0);
    peer_take();
    check("R7 irq after take", {7'd0, irq}, 8'd1);
    ie_out = 1'b0;
    @(negedge clk); check("R7 irq masked", {7'd0, irq}, 8'd0);

    // R8 read meets strobe edge
    peer_send(8'h42);
    @(negedge clk); tb_drv = 1'b1; tb_val = 8'h99; stb_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; in_q.push_back(8'h99);
    check("R8 set wins", {7'd0, in_full}, 8'd1);
    stb_n = 1'b1;
    repeat (3) @(negedge clk);
    tb_drv = 1'b0;
    host_read();

    // R8 write meets acknowledge edge
    host_write(8'h77);
    void'(out_q.pop_front());
    @(negedge clk); ack_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'hE4;
    @(negedge clk); host_wr = 1'b0; out_q.push_back(8'hE4);
    check("R8 write wins", {7'd0, out_full_n}, 8'd0);
    check("R6 pad new byte", pad, 8'hE4);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
    peer_take();

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule